// File: doc/BRIEF.md
# Synchronized Clock Output Gating Controller

This block sits after the clock synthesizer and decides, for every derived clock output, whether it runs or is held low. The outputs come in four groups: processor, graphics, PCI and miscellaneous. An output runs only when its enable bit allows it and when the stop pin for its group allows it. The enable bits come from a serial configuration register held outside the block, in the reference clock domain.

The two active-low stop pins are synchronized to the free-running PCI reference clock. A mode input can switch the stop function off. The run request for each output is registered on the reference clock. It is then taken into a flop on the falling edge of the gated clock itself. Because of this, an output only changes state while its clock is low: it never stops with a short high pulse and it always rests low.

After reset, a settle counter keeps every output off until the oscillator has had time to stabilize. The reference clock is passed through ungated.

Top module: `clk_out_gate_ctrl`

## Requirements
- R1: A stopped output is held at 0, and every high pulse on a gated output lasts a full high phase of its source clock. Outputs never stop with a shortened pulse.
- R2: A stop-pin change has no effect on any output until at least two rising edges of `ref_clk_i` have passed. After that, the output switches state on a falling edge of its own source clock.
- R3: An output runs only while its bit in `clk_en_i` is 1. The bit order is processor outputs from bit 0, then graphics, then PCI, then miscellaneous.
- R4: With `mode_i`=0, driving `cpu_stop_ni` low stops the processor and graphics outputs. The PCI and miscellaneous outputs keep running.
- R5: With `mode_i`=0, driving `pci_stop_ni` low stops the PCI outputs only. `ref_clk_o` keeps toggling at all times, including during the hold-off.
- R6: After reset is released, all gated outputs stay at 0 for SETTLE_CYCLES cycles of `ref_clk_i`.
- R7: With `mode_i`=1, both stop pins are ignored and each output follows only its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Free-running PCI reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 disables the stop pins |
| cpu_stop_ni | input | 1 | Active-low stop for the processor and graphics groups |
| pci_stop_ni | input | 1 | Active-low stop for the PCI group |
| clk_en_i | input | N_CPU+N_AGP+N_PCI+N_OTH | Per-output register enable |
| cpu_clk_i | input | N_CPU | Processor source clocks |
| agp_clk_i | input | N_AGP | Graphics source clocks |
| pci_clk_i | input | N_PCI | PCI source clocks |
| oth_clk_i | input | N_OTH | Miscellaneous source clocks |
| ref_clk_o | output | 1 | Ungated reference clock |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| agp_clk_o | output | N_AGP | Gated graphics clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| oth_clk_o | output | N_OTH | Gated miscellaneous clocks |

## Verification
The bench applies several enable patterns: all set, alternating bits, and a single bit. These separate a wrong bit order from a wrong group mapping. Each stop pin is then asserted alone and both together, in both modes. This separates the mode qualification from the group decode. A stop applied just after a reference edge shows whether the synchronizer delay is present. The high-pulse width monitors, which run on every output with unrelated source clock periods, catch gating that acts on the wrong edge.

// File: rtl/clk_gate_pkg.sv
`timescale 1ns/1ps
package clk_gate_pkg;
  typedef enum logic [1:0] {
    GRP_CPU = 2'd0,
    GRP_AGP = 2'd1,
    GRP_PCI = 2'd2,
    GRP_OTH = 2'd3
  } clk_grp_e;

  // which stop qualifier applies to a group
  function automatic logic grp_allowed(clk_grp_e g, logic cpu_ok, logic pci_ok);
    case (g)
      GRP_CPU, GRP_AGP: grp_allowed = cpu_ok;
      GRP_PCI:          grp_allowed = pci_ok;
      default:          grp_allowed = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/clk_gate_sync.sv
`timescale 1ns/1ps
module clk_gate_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/clk_settle_timer.sv
`timescale 1ns/1ps
module clk_settle_timer #(
  parameter int unsigned CYCLES = 100_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;

  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o
);
  logic en_q;

  // enable changes only while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= run_i;
  end

  assign clk_o = clk_i & en_q;

  p_follow_req_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    run_i |=> en_q);
  p_stop_req_r1: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !run_i |=> !en_q);
endmodule

// File: rtl/clk_out_gate_ctrl.sv
`timescale 1ns/1ps
module clk_out_gate_ctrl
  import clk_gate_pkg::*;
#(
  parameter int unsigned N_CPU = 2,
  parameter int unsigned N_AGP = 1,
  parameter int unsigned N_PCI = 3,
  parameter int unsigned N_OTH = 2,
  parameter int unsigned SETTLE_CYCLES = 100_000
) (
  input  logic                             ref_clk_i,
  input  logic                             rst_ni,
  input  logic                             mode_i,
  input  logic                             cpu_stop_ni,
  input  logic                             pci_stop_ni,
  input  logic [N_CPU+N_AGP+N_PCI+N_OTH-1:0] clk_en_i,
  input  logic [N_CPU-1:0]                 cpu_clk_i,
  input  logic [N_AGP-1:0]                 agp_clk_i,
  input  logic [N_PCI-1:0]                 pci_clk_i,
  input  logic [N_OTH-1:0]                 oth_clk_i,
  output logic                             ref_clk_o,
  output logic [N_CPU-1:0]                 cpu_clk_o,
  output logic [N_AGP-1:0]                 agp_clk_o,
  output logic [N_PCI-1:0]                 pci_clk_o,
  output logic [N_OTH-1:0]                 oth_clk_o
);
  localparam int unsigned AGP_LO = N_CPU;
  localparam int unsigned PCI_LO = N_CPU + N_AGP;
  localparam int unsigned OTH_LO = PCI_LO + N_PCI;
  localparam int unsigned N_ALL  = OTH_LO + N_OTH;

  function automatic clk_grp_e grp_of(int unsigned idx);
    if (idx < AGP_LO)      grp_of = GRP_CPU;
    else if (idx < PCI_LO) grp_of = GRP_AGP;
    else if (idx < OTH_LO) grp_of = GRP_PCI;
    else                   grp_of = GRP_OTH;
  endfunction

  logic             mode_s, cpu_stop_s, pci_stop_s;
  logic             settled;
  logic             cpu_ok, pci_ok;
  logic [N_ALL-1:0] run_d, req_q;
  logic [N_ALL-1:0] src_clk, gated_clk;

  clk_gate_sync #(.W(3), .RST_VAL(3'b011)) u_pin_sync (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({mode_i, cpu_stop_ni, pci_stop_ni}),
    .q_o    ({mode_s, cpu_stop_s, pci_stop_s})
  );

  clk_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .done_o (settled)
  );

  assign cpu_ok = mode_s | cpu_stop_s;
  assign pci_ok = mode_s | pci_stop_s;

  assign src_clk = {oth_clk_i, pci_clk_i, agp_clk_i, cpu_clk_i};

  for (genvar i = 0; i < N_ALL; i++) begin : g_out
    assign run_d[i] = clk_en_i[i] & grp_allowed(grp_of(i), cpu_ok, pci_ok);

    clk_gate_cell u_cell (
      .clk_i  (src_clk[i]),
      .rst_ni (rst_ni),
      .run_i  (req_q[i]),
      .clk_o  (gated_clk[i])
    );
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= run_d & {N_ALL{settled}};
  end

  assign ref_clk_o = ref_clk_i;
  assign cpu_clk_o = gated_clk[AGP_LO-1:0];
  assign agp_clk_o = gated_clk[PCI_LO-1:AGP_LO];
  assign pci_clk_o = gated_clk[OTH_LO-1:PCI_LO];
  assign oth_clk_o = gated_clk[N_ALL-1:OTH_LO];

  p_holdoff_r6: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !settled |=> (req_q == '0));
  p_reg_off_r3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    settled |=> ((req_q & ~$past(clk_en_i)) == '0));
  p_cpu_stop_r4: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (!mode_s && !cpu_stop_s) |=> (req_q[PCI_LO-1:0] == '0));
  p_pci_stop_r5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (!mode_s && !pci_stop_s) |=> (req_q[OTH_LO-1:PCI_LO] == '0));
  p_mode_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (mode_s && settled) |=> (req_q == $past(clk_en_i)));
endmodule

// File: tb/clk_out_gate_ctrl_bench.sv
`timescale 1ns/1ps
module clk_out_gate_ctrl_bench;
  localparam int N_CPU = 2, N_AGP = 1, N_PCI = 3, N_OTH = 2;
  localparam int N_ALL = N_CPU + N_AGP + N_PCI + N_OTH;
  localparam int SETTLE = 40;

  logic ref_clk = 1'b0, rst_ni = 1'b0, mode = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
  logic [N_ALL-1:0] en = '1;
  logic cpu_c = 1'b0, agp_c = 1'b0, pci_c = 1'b0, oth_c = 1'b0;
  logic ref_o;
  logic [N_CPU-1:0] cpu_o;
  logic [N_AGP-1:0] agp_o;
  logic [N_PCI-1:0] pci_o;
  logic [N_OTH-1:0] oth_o;
  logic [N_ALL-1:0] all_o;

  int checks = 0, bad = 0, glitch_bad = 0, ref_rises = 0;
  int rise_cnt [N_ALL];
  bit done = 0;

  always #2.5 ref_clk = ~ref_clk;
  initial begin #0.7; forever #3 cpu_c = ~cpu_c; end
  initial begin #1.1; forever #7 agp_c = ~agp_c; end
  initial begin #1.3; forever #5 pci_c = ~pci_c; end
  initial begin #0.4; forever #4 oth_c = ~oth_c; end

  clk_out_gate_ctrl #(.N_CPU(N_CPU), .N_AGP(N_AGP), .N_PCI(N_PCI),
    .N_OTH(N_OTH), .SETTLE_CYCLES(SETTLE)) u_clk_out_gate_ctrl (
    .ref_clk_i(ref_clk), .rst_ni(rst_ni), .mode_i(mode),
    .cpu_stop_ni(cpu_stop_n), .pci_stop_ni(pci_stop_n), .clk_en_i(en),
    .cpu_clk_i({N_CPU{cpu_c}}), .agp_clk_i({N_AGP{agp_c}}),
    .pci_clk_i({N_PCI{pci_c}}), .oth_clk_i({N_OTH{oth_c}}),
    .ref_clk_o(ref_o), .cpu_clk_o(cpu_o), .agp_clk_o(agp_o),
    .pci_clk_o(pci_o), .oth_clk_o(oth_o));

  assign all_o = {oth_o, pci_o, agp_o, cpu_o};

  function automatic real half_of(int i);
    if (i < N_CPU) return 3.0;
    if (i < N_CPU + N_AGP) return 7.0;
    if (i < N_CPU + N_AGP + N_PCI) return 5.0;
    return 4.0;
  endfunction

  always @(posedge ref_o) ref_rises++;

  for (genvar g = 0; g < N_ALL; g++) begin : g_mon
    realtime t_r = -1.0;
    initial rise_cnt[g] = 0;
    always @(posedge all_o[g]) begin
      rise_cnt[g]++;
      t_r = $realtime;
    end
    always @(negedge all_o[g]) begin
      if (t_r >= 0.0 && ($realtime - t_r) < half_of(g) - 0.01) begin
        glitch_bad++;
        $display("FAIL R1: out %0d high width actual=%0.3f expected=%0.3f",
                 g, $realtime - t_r, half_of(g));
      end
    end
  end

  function automatic logic [N_ALL-1:0] model(logic [N_ALL-1:0] e, logic m,
                                              logic cs_n, logic ps_n);
    logic [N_ALL-1:0] r;
    for (int i = 0; i < N_ALL; i++) begin
      logic ok;
      if (i < N_CPU + N_AGP) ok = m | cs_n;
      else if (i < N_CPU + N_AGP + N_PCI) ok = m | ps_n;
      else ok = 1'b1;
      r[i] = e[i] & ok;
    end
    return r;
  endfunction

  // observe which outputs toggle over a window, and that idle ones sit low
  task automatic expect_run(string req, logic [N_ALL-1:0] exp);
    int snap [N_ALL];
    logic [N_ALL-1:0] act;
    logic [N_ALL-1:0] hi_seen = '0;
    for (int i = 0; i < N_ALL; i++) snap[i] = rise_cnt[i];
    for (int k = 0; k < 30; k++) begin
      #2.1;
      hi_seen |= all_o & ~exp;
    end
    for (int i = 0; i < N_ALL; i++) act[i] = (rise_cnt[i] != snap[i]);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: running actual=%b expected=%b", req, act, exp);
    end
    checks++;
    if (hi_seen != '0) begin
      bad++;
      $display("FAIL R1: stopped outputs high actual=%b expected=%b", hi_seen, '0);
    end
  endtask

  task automatic settle_wait(int n);
    repeat (n) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  task automatic apply(logic [N_ALL-1:0] e, logic m, logic cs_n, logic ps_n, string req);
    @(negedge ref_clk);
    en = e; mode = m; cpu_stop_n = cs_n; pci_stop_n = ps_n;
    settle_wait(8);
    expect_run(req, model(e, m, cs_n, ps_n));
  endtask

  task automatic t_reset_holdoff();
    int r0;
    rst_ni = 1'b0;
    #12.5;
    checks++;
    if (all_o !== '0) begin
      bad++;
      $display("FAIL R6: reset outputs actual=%b expected=%b", all_o, '0);
    end
    @(negedge ref_clk);
    rst_ni = 1'b1;
    r0 = ref_rises;
    settle_wait(3);
    expect_run("R6", '0);
    checks++;
    if (ref_rises - r0 < 10) begin
      bad++;
      $display("FAIL R5: ref_clk_o rises actual=%0d expected>=10", ref_rises - r0);
    end
    settle_wait(SETTLE);
    expect_run("R6", '1);
  endtask

  task automatic t_enable_patterns();
    apply(8'b1010_1010, 1'b0, 1'b1, 1'b1, "R3");
    apply(8'b0101_0101, 1'b0, 1'b1, 1'b1, "R3");
    apply(8'b0000_1000, 1'b0, 1'b1, 1'b1, "R3");
    apply('1, 1'b0, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_stop_pins();
    int r0;
    apply('1, 1'b0, 1'b0, 1'b1, "R4");
    apply(8'b1100_0110, 1'b0, 1'b0, 1'b1, "R4");
    r0 = ref_rises;
    apply('1, 1'b0, 1'b1, 1'b0, "R5");
    checks++;
    if (ref_rises - r0 < 10) begin
      bad++;
      $display("FAIL R5: ref_clk_o rises actual=%0d expected>=10", ref_rises - r0);
    end
    apply('1, 1'b0, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_mode();
    apply('1, 1'b1, 1'b0, 1'b0, "R7");
    apply(8'b0011_1001, 1'b1, 1'b0, 1'b0, "R7");
    apply('1, 1'b0, 1'b1, 1'b1, "R7");
  endtask

  task automatic t_latency();
    int snap0, snap1;
    @(negedge ref_clk);
    snap0 = rise_cnt[0];
    snap1 = rise_cnt[1];
    cpu_stop_n = 1'b0;
    #7;
    checks++;
    if (rise_cnt[0] == snap0 || rise_cnt[1] == snap1) begin
      bad++;
      $display("FAIL R2: early stop rises actual=%0d/%0d expected>0",
               rise_cnt[0] - snap0, rise_cnt[1] - snap1);
    end
    settle_wait(8);
    expect_run("R2", model('1, 1'b0, 1'b0, 1'b1));
    @(negedge ref_clk);
    cpu_stop_n = 1'b1;
    settle_wait(8);
    expect_run("R2", '1);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    checks++;
    if (glitch_bad != 0) bad++;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    t_reset_holdoff();
    t_enable_patterns();
    t_stop_pins();
    t_mode();
    t_latency();
    finish_run();
  end

  initial begin
    #200000;
    checks++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule